// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides whether a PLL has reached frequency lock. It compares a divided feedback clock with a reference clock and reports the result on two lock flags. Both clocks come in as ordinary signals and are sampled by a faster system clock. Each input passes through a two-flop synchronizer and a rising-edge detector. Two counters then count whole periods of each input. When the reference count reaches one of three checkpoints, at 16, 32 and 64 edges, the block compares the two counts. A one-cycle strobe marks every comparison.

Lock is declared in two stages. An exact match at the 32-edge checkpoint raises `lock0`. A further match at the 64-edge checkpoint also raises `lock1`, restarts both counters and opens a new measurement window. The flags drop on any of these events:

- a failed comparison;
- a pulse on `div_wr`, which signals a write to the feedback divide setting;
- `lock_en` going low;
- `pwr_down` going high;
- the reset.

The control is a four-state machine:

- `ST_OFF`: the detector is disabled.
- `ST_SEEK`: measuring, with no flag set.
- `ST_HALF`: `lock0` only.
- `ST_FULL`: both flags.

Transitions:

- Enable: `ST_OFF` to `ST_SEEK` when the block runs.
- First lock: `ST_SEEK` to `ST_HALF` on a match at 32.
- Second lock: `ST_HALF` to `ST_FULL` on a match at 64.
- Mismatch: `ST_HALF` or `ST_FULL` to `ST_SEEK` when a comparison fails.
- Divider write: any state to `ST_SEEK` on `div_wr`.
- Disable: any state to `ST_OFF` when `lock_en` is low or `pwr_down` is high.
- Hold: all other cases keep the current state.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low, `lock_en` is low or `pwr_down` is high, both counters are held at zero and `lock0`, `lock1` and `chk_stb` are 0 from the next clock edge.
- R2: Each counter advances once per rising edge of its synchronized input, so only whole periods count. The duty cycle of the feedback input has no effect on the result.
- R3: A comparison takes place on the reference edge that brings the reference count to 16, 32 or 64. `chk_stb` is high for exactly one cycle per comparison, and the reference count never exceeds 64.
- R4: If the counts are exactly equal at the 32-edge checkpoint, `lock0` becomes 1 in the same cycle as the strobe.
- R5: If the counts are also equal at the 64-edge checkpoint, `lock1` becomes 1 as well and both counters restart. Flags then stay set while later windows keep matching. `lock1` is never 1 while `lock0` is 0.
- R6: Unequal counts at any checkpoint clear both flags and restart both counters.
- R7: A one-cycle pulse on `div_wr` clears both flags at the next edge and restarts both counters. Lock is regained after a fresh 32-edge match.
- R8: After lock, lowering `lock_en` or raising `pwr_down` clears both flags at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 4x faster than either monitored input |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Enables the detector |
| pwr_down | input | 1 | PLL powered down; holds the detector in reset |
| div_wr | input | 1 | One-cycle pulse on a write to the feedback divide setting |
| ref_in | input | 1 | Reference clock, sampled as data |
| fb_in | input | 1 | Divided feedback clock, sampled as data |
| chk_stb | output | 1 | One-cycle strobe at each comparison |
| lock0 | output | 1 | First-stage lock flag |
| lock1 | output | 1 | Second-stage lock flag |

## Verification
Some rules are checked on every cycle:

- `lock1` implies `lock0`.
- A disable, power-down or divider write clears the flags one edge later.
- A flag only rises together with a strobe.
- A flag only falls after a strobe, a divider write or a disable.
- The strobe never lasts two cycles.
- The reference count stays within 64.

The bench scenarios cover what the assertions cannot see:

- the exact two-stage lock sequence;
- strobe counts across several windows, for matched and mismatched periods;
- whether an odd feedback duty cycle leaves the result unchanged;
- relock after a divider write.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SEEK,
        ST_HALF,
        ST_FULL
    } lock_state_t;

endpackage

// File: rtl/edge_sync.sv
// Two-flop synchronizer followed by a rising-edge detector.
module edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/edge_count.sv
// Period counter; clear has priority over increment.
module edge_count #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (inc)
            count <= count + W'(1);
    end
endmodule

// File: rtl/lock_fsm.sv
// Two-stage lock state machine with checkpoint strobe.
module lock_fsm
    import lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_wr,
    input  logic ckpt,
    input  logic match,
    input  logic at_mid,
    input  logic at_last,
    output logic restart,
    output logic chk_stb,
    output logic lock0,
    output logic lock1
);
    lock_state_t state_q, state_d;
    logic        stb_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (run) state_d = ST_SEEK;
            ST_SEEK: if (ckpt && match && at_mid) state_d = ST_HALF;
            ST_HALF: begin
                if (ckpt && !match)
                    state_d = ST_SEEK;
                else if (ckpt && match && at_last)
                    state_d = ST_FULL;
            end
            ST_FULL: if (ckpt && !match) state_d = ST_SEEK;
            default: state_d = ST_OFF;
        endcase
        if (div_wr && state_d != ST_OFF)
            state_d = ST_SEEK;
        if (!run)
            state_d = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            stb_q   <= run & ckpt;
        end
    end

    always_comb begin
        lock0   = (state_q == ST_HALF) || (state_q == ST_FULL);
        lock1   = (state_q == ST_FULL);
        chk_stb = stb_q;
        restart = !run || div_wr || (ckpt && (!match || at_last));
    end
endmodule

// File: rtl/pll_lock_monitor.sv
// Top: frequency lock detector comparing reference and feedback period counts.
module pll_lock_monitor #(
    parameter int BASE_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_en,
    input  logic pwr_down,
    input  logic div_wr,
    input  logic ref_in,
    input  logic fb_in,
    output logic chk_stb,
    output logic lock0,
    output logic lock1
);
    localparam int FIRST_CK = 1 << BASE_LOG2;
    localparam int MID_CK   = 2 * FIRST_CK;
    localparam int LAST_CK  = 4 * FIRST_CK;
    localparam int CNT_W    = $clog2(LAST_CK) + 1;

    logic [1:0]       raw_in;
    logic [1:0]       rise;
    logic             run;
    logic             restart;
    logic [CNT_W-1:0] ref_count, fb_count;
    logic [CNT_W-1:0] ref_next, fb_next;
    logic             at_first, at_mid, at_last, ckpt, match;

    assign raw_in = {fb_in, ref_in};
    assign run    = lock_en & ~pwr_down;

    // index 0: reference, index 1: feedback
    for (genvar g = 0; g < 2; g++) begin : g_sync
        edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    edge_count #(.W(CNT_W)) u_ref_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(restart),
        .inc  (rise[0]),
        .count(ref_count)
    );

    edge_count #(.W(CNT_W)) u_fb_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(restart),
        .inc  (rise[1]),
        .count(fb_count)
    );

    assign ref_next = ref_count + CNT_W'(rise[0]);
    assign fb_next  = fb_count + CNT_W'(rise[1]);
    assign at_first = (ref_next == CNT_W'(FIRST_CK));
    assign at_mid   = (ref_next == CNT_W'(MID_CK));
    assign at_last  = (ref_next == CNT_W'(LAST_CK));
    assign ckpt     = rise[0] & (at_first | at_mid | at_last);
    assign match    = (fb_next == ref_next);

    lock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_wr (div_wr),
        .ckpt   (ckpt),
        .match  (match),
        .at_mid (at_mid),
        .at_last(at_last),
        .restart(restart),
        .chk_stb(chk_stb),
        .lock0  (lock0),
        .lock1  (lock1)
    );
endmodule

// File: rtl/pll_lock_checker.sv
// Cycle-level properties of the lock detector, bound to the top.
module pll_lock_checker #(
    parameter int CNT_W   = 7,
    parameter int LAST_CK = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_en,
    input logic             pwr_down,
    input logic             div_wr,
    input logic             chk_stb,
    input logic             lock0,
    input logic             lock1,
    input logic [CNT_W-1:0] ref_cnt
);
    a_r5_lock1_implies_lock0: assert property (@(posedge clk) disable iff (!rst_n)
        lock1 |-> lock0);

    a_r1_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_en || pwr_down) |=> (!lock0 && !lock1 && !chk_stb));

    a_r8_pwrdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !lock0);

    a_r7_divwr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (!lock0 && !lock1));

    a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        chk_stb |=> !chk_stb);

    a_r3_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= CNT_W'(LAST_CK));

    a_r4_lock0_rise_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock0) |-> chk_stb);

    a_r5_lock1_rise_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock1) |-> chk_stb);

    a_r6_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock0) |-> (chk_stb || $past(div_wr) || $past(!lock_en || pwr_down)));
endmodule

bind pll_lock_monitor pll_lock_checker #(
    .CNT_W  (CNT_W),
    .LAST_CK(LAST_CK)
) u_lock_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_en (lock_en),
    .pwr_down(pwr_down),
    .div_wr  (div_wr),
    .chk_stb (chk_stb),
    .lock0   (lock0),
    .lock1   (lock1),
    .ref_cnt (ref_count)
);

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_en = 1'b0;
    logic pwr_down = 1'b0;
    logic div_wr = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic chk_stb, lock0, lock1;

    int checks = 0;
    int errors = 0;
    int stb_seen = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_lock_monitor dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_en (lock_en),
        .pwr_down(pwr_down),
        .div_wr  (div_wr),
        .ref_in  (ref_in),
        .fb_in   (fb_in),
        .chk_stb (chk_stb),
        .lock0   (lock0),
        .lock1   (lock1)
    );

    always @(negedge clk) begin
        cycles++;
        if (chk_stb) stb_seen++;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // expected {lock1,lock0} after n reference periods in one window
    function automatic logic [1:0] exp_flags(bit matched, int n);
        if (!matched) return 2'b00;
        if (n >= 64) return 2'b11;
        if (n >= 32) return 2'b01;
        return 2'b00;
    endfunction

    function automatic int exp_stb(bit matched, int n);
        int w = 0;
        int c = 0;
        for (int e = 1; e <= n; e++) begin
            w++;
            if (matched) begin
                if (w == 16 || w == 32) c++;
                if (w == 64) begin c++; w = 0; end
            end else if (w == 16) begin
                c++; w = 0;
            end
        end
        return c;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive both inputs for n reference periods; feedback edge leads by lead
    task automatic run_periods(int n, int pr, int pf, int fbhigh, int lead, int wr_at);
        for (int t = 0; t < n * pr; t++) begin
            @(negedge clk);
            ref_in = (((t + pr - lead) % pr) < pr / 2);
            fb_in  = ((t % pf) < fbhigh);
            div_wr = (wr_at >= 0 && t == wr_at * pr + pr - 2);
        end
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic restart_detector();
        @(negedge clk);
        lock_en = 1'b0;
        ref_in  = 1'b0;
        fb_in   = 1'b0;
        wait_cycles(6);
        lock_en = 1'b1;
        wait_cycles(2);
        stb_seen = 0;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        wait_cycles(3);
        check("R1 reset flags", int'({lock1, lock0}), 0);
        check("R1 reset strobe", int'(chk_stb), 0);
        rst_n = 1'b1;
        wait_cycles(2);

        // disabled: inputs toggle but nothing happens
        run_periods(40, 10, 10, 5, 2, -1);
        wait_cycles(6);
        check("R1 disabled flags", int'({lock1, lock0}), 0);
        check("R1 disabled strobe", stb_seen, 0);

        // directed matched run with narrow feedback pulses (R2)
        restart_detector();
        run_periods(24, 10, 10, 2, 2, -1);
        wait_cycles(6);
        check("R3 no flag at 16", int'({lock1, lock0}), 0);
        check("R3 one strobe by 24", stb_seen, 1);
        run_periods(16, 10, 10, 2, 2, -1);
        wait_cycles(6);
        check("R4 lock0 after 32", int'({lock1, lock0}), 1);
        check("R2 narrow duty lock0", int'(lock0), 1);
        run_periods(30, 10, 10, 2, 2, -1);
        wait_cycles(6);
        check("R5 lock1 after 64", int'({lock1, lock0}), 3);
        check("R3 strobes by 70", stb_seen, 3);
        run_periods(64, 10, 10, 2, 2, -1);
        wait_cycles(6);
        check("R5 persists next window", int'({lock1, lock0}), 3);
        check("R5 window restart strobes", stb_seen, 6);

        // divider write clears, then relock
        run_periods(5, 10, 10, 2, 2, 2);
        wait_cycles(2);
        check("R7 div_wr clears", int'({lock1, lock0}), 0);
        run_periods(40, 10, 10, 2, 2, -1);
        wait_cycles(6);
        check("R7 relock lock0", int'({lock1, lock0}), 1);

        // feedback drifts off frequency
        run_periods(40, 10, 13, 6, 2, -1);
        wait_cycles(6);
        check("R6 mismatch clears", int'({lock1, lock0}), 0);

        // power-down after lock
        restart_detector();
        run_periods(70, 9, 9, 4, 1, -1);
        wait_cycles(6);
        check("R5 relock full", int'({lock1, lock0}), 3);
        @(negedge clk);
        pwr_down = 1'b1;
        @(negedge clk);
        check("R8 pwr_down clears", int'({lock1, lock0}), 0);
        pwr_down = 1'b0;

        // lock_en drop after lock
        restart_detector();
        run_periods(70, 12, 12, 3, 3, -1);
        wait_cycles(6);
        check("R5 relock full 2", int'({lock1, lock0}), 3);
        @(negedge clk);
        lock_en = 1'b0;
        @(negedge clk);
        check("R8 lock_en drop clears", int'({lock1, lock0}), 0);

        // constrained random scenarios
        for (int it = 0; it < 10; it++) begin
            int pr, pf, lead, fbh, n;
            bit matched;
            pr      = 8 + int'($urandom_range(6));
            lead    = 1 + int'($urandom_range(2));
            matched = 1'($urandom_range(1));
            if (matched) pf = pr;
            else if ($urandom_range(1) == 1) pf = pr + 2 + int'($urandom_range(1));
            else pf = pr - 2;
            fbh = 2 + int'($urandom_range(pf - 4));
            n   = 20 + int'($urandom_range(80));
            restart_detector();
            run_periods(n, pr, pf, fbh, lead, -1);
            wait_cycles(6);
            check(matched ? "R2 R4 R5 random flags" : "R6 random flags",
                  int'({lock1, lock0}), int'(exp_flags(matched, n % 64 == n ? n : (n >= 64 ? 64 : n))));
            check("R3 random strobes", stb_seen, exp_stb(matched, n));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule